// File: doc/BRIEF.md
# Byte-Wide Multicycle Processor Datapath

This block is the data-handling half of a small multicycle processor with an 8-bit data path. An external controller sequences it one step per clock. That controller drives the multiplexer selects, the write enables and a 3-bit ALU operation code. A byte-wide external memory feeds read data into the block and receives an address and write data from it. The datapath sends back the instruction opcode and function fields, and a zero flag, so the controller can pick its next step.

A 32-bit instruction reaches the block over four cycles. Each cycle drops one memory byte into the instruction register under a per-byte enable. The register fields then steer the rest of the datapath:
- two source register numbers and two candidate destination numbers,
- an 8-bit immediate,
- a 6-bit jump field that is multiplied by four to give an absolute target.

The PC steps by one byte at a time, through the ALU. Four registers are loaded on every clock without an enable:
- the two operand registers A and B,
- the memory data register,
- the ALU output register.

This lets a value from one step be consumed in the next.

Top module: `byte_datapath`

## Requirements
- R1: While reset is high at a clock edge, every state register is cleared at that edge: PC, instruction register, all register-file entries, A, B, memory data register and ALU output register.
- R2: Instruction register byte k is loaded from memory read data when enable bit k is high, and holds otherwise. Bit 0 is bits [7:0] and bit 3 is bits [31:24]. The opcode output is bits [31:26] and the function output is bits [5:0].
- R3: Register 0 reads as zero, and a write aimed at it has no visible effect.
- R4: The register write address is the low 3 bits of instruction bits [20:16] when the destination select is 0, and of bits [15:11] when it is 1. The write data is the ALU output register when the write-source select is 0, and the memory data register when it is 1.
- R5: ALU operand X is the PC when its select is 0, and register A when it is 1.
- R6: ALU operand Y is chosen by a 2-bit select: 00 gives register B, 01 gives the constant 1, 10 gives instruction bits [7:0], and 11 gives instruction bits [7:0] shifted left by two (8-bit result).
- R7: The PC loads only when the PC enable is high. Its next value is chosen by a 2-bit select: 00 gives the live ALU result, 01 gives the ALU output register, and 10 or 11 give instruction bits [5:0] shifted left by two.
- R8: The memory address is the PC when the address select is 0, and the ALU output register when it is 1.
- R9: ALU operation codes: 000 is AND, 001 is OR, 010 is add, 110 is subtract, and 111 is signed set-less-than (result 1 or 0). Any other code gives 0. The ALU output register captures the result on every clock.
- R10: The zero output is high exactly when the current 8-bit ALU result is zero.
- R11: On every clock, A captures the register selected by bits [25:21], B the register selected by bits [20:16], and the memory data register the memory read data. The memory write data output is B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Memory read data |
| src_x_sel | input | 1 | ALU operand X select |
| src_y_sel | input | 2 | ALU operand Y select |
| pc_next_sel | input | 2 | Next-PC select |
| pc_load | input | 1 | PC enable |
| addr_sel | input | 1 | Memory address select |
| ir_load | input | 4 | Instruction register byte enables |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination register field select |
| wb_sel | input | 1 | Register write data select |
| alu_ctl | input | 3 | ALU operation code |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| opcode | output | 6 | Instruction bits [31:26] |
| func | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The bench builds the block with its default parameters: 8-bit data, four instruction bytes and eight registers. With only 256 values per byte, random operands regularly hit the interesting corners:
- the PC wrapping from 255 to 0,
- subtraction borrows,
- set-less-than across the sign boundary,
- immediates whose top bits are lost when shifted left by two.

The behavioural model tracks every register. Each cycle it compares the address, write data, opcode, function and zero outputs, so hidden state shows up once it reaches a port.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam int OPCODE_W = 6;
  localparam int FUNC_W   = 6;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;

endpackage

// File: rtl/dp_instr_reg.sv
module dp_instr_reg #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NBYTES-1:0]          byte_we,
  input  logic [BYTE_W-1:0]          byte_in,
  output logic [NBYTES*BYTE_W-1:0]   word_q
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        word_q[k*BYTE_W +: BYTE_W] <= '0;
      else if (byte_we[k])
        word_q[k*BYTE_W +: BYTE_W] <= byte_in;
    end
  end

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (byte_we == '0) |=> $stable(word_q)); // R2

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra0,
  input  logic [AW-1:0]     ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  always_comb begin
    rd0 = (ra0 == '0) ? '0 : mem[ra0];
    rd1 = (ra1 == '0) ? '0 : mem[ra1];
  end

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (mem[$past(wa)] == $past(wd))); // R4

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit SLT_SIGNED = 1'b1
) (
  input  logic [2:0]        ctl,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);

  logic less;

  if (SLT_SIGNED) begin : g_signed
    assign less = ($signed(x) < $signed(y));
  end else begin : g_unsigned
    assign less = (x < y);
  end

  always_comb begin
    unique case (alu_op_e'(ctl))
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      ALU_ADD: res = x + y;
      ALU_SUB: res = x - y;
      ALU_SLT: res = DATA_W'(less);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/byte_datapath.sv
module byte_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INSTR_BYTES = 4,
  parameter int REG_COUNT   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               src_x_sel,
  input  logic [1:0]         src_y_sel,
  input  logic [1:0]         pc_next_sel,
  input  logic               pc_load,
  input  logic               addr_sel,
  input  logic [INSTR_BYTES-1:0] ir_load,
  input  logic               rf_we,
  input  logic               dst_sel,
  input  logic               wb_sel,
  input  logic [2:0]         alu_ctl,
  output logic [DATA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [OPCODE_W-1:0] opcode,
  output logic [FUNC_W-1:0]  func,
  output logic               alu_zero
);

  localparam int INSTR_W = DATA_W * INSTR_BYTES;
  localparam int RA_W    = $clog2(REG_COUNT);
  localparam int JFLD_W  = 6;

  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  pc_q, a_q, b_q, mdr_q, aluout_q;
  logic [DATA_W-1:0]  rf_rd0, rf_rd1, rf_wd;
  logic [RA_W-1:0]    rs_a, rt_a, rd_a, wr_a;
  logic [DATA_W-1:0]  imm, imm_x4, jump_tgt;
  logic [DATA_W-1:0]  op_x, op_y, alu_y, pc_nxt;

  dp_instr_reg #(.BYTE_W(DATA_W), .NBYTES(INSTR_BYTES)) u_ir (
    .clk     (clk),
    .rst     (rst),
    .byte_we (ir_load),
    .byte_in (mem_rdata),
    .word_q  (ir_q)
  );

  assign rs_a     = ir_q[RS_LSB +: RA_W];
  assign rt_a     = ir_q[RT_LSB +: RA_W];
  assign rd_a     = ir_q[RD_LSB +: RA_W];
  assign wr_a     = dst_sel ? rd_a : rt_a;
  assign rf_wd    = wb_sel ? mdr_q : aluout_q;
  assign imm      = ir_q[DATA_W-1:0];
  assign imm_x4   = {imm[DATA_W-3:0], 2'b00};
  assign jump_tgt = DATA_W'({ir_q[JFLD_W-1:0], 2'b00});

  dp_regfile #(.DATA_W(DATA_W), .DEPTH(REG_COUNT)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (wr_a),
    .wd  (rf_wd),
    .ra0 (rs_a),
    .ra1 (rt_a),
    .rd0 (rf_rd0),
    .rd1 (rf_rd1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      mdr_q    <= '0;
      aluout_q <= '0;
    end else begin
      a_q      <= rf_rd0;
      b_q      <= rf_rd1;
      mdr_q    <= mem_rdata;
      aluout_q <= alu_y;
    end
  end

  always_comb begin
    op_x = src_x_sel ? a_q : pc_q;
    unique case (src_y_sel)
      2'b00:   op_y = b_q;
      2'b01:   op_y = DATA_W'(1);
      2'b10:   op_y = imm;
      default: op_y = imm_x4;
    endcase
  end

  dp_alu #(.DATA_W(DATA_W), .SLT_SIGNED(1'b1)) u_alu (
    .ctl (alu_ctl),
    .x   (op_x),
    .y   (op_y),
    .res (alu_y)
  );

  always_comb begin
    unique case (pc_next_sel)
      2'b00:   pc_nxt = alu_y;
      2'b01:   pc_nxt = aluout_q;
      default: pc_nxt = jump_tgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_load) pc_q <= pc_nxt;
  end

  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[INSTR_W-1 -: OPCODE_W];
  assign func      = ir_q[FUNC_W-1:0];
  assign alu_zero  = (alu_y == '0);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pc_load |=> $stable(pc_q)); // R7

  AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mdr_q == $past(mem_rdata))); // R11

  AST_ALUOUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (aluout_q == $past(alu_y))); // R9

  AST_WDATA_IS_B: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_wdata == $past(rf_rd1))); // R11

endmodule

// File: tb/tb_byte_datapath.sv
`timescale 1ns/1ps
module tb_byte_datapath;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] mem_rdata;
  logic       src_x_sel, pc_load, addr_sel, rf_we, dst_sel, wb_sel;
  logic [1:0] src_y_sel, pc_next_sel;
  logic [3:0] ir_load;
  logic [2:0] alu_ctl;
  logic [7:0] mem_addr, mem_wdata;
  logic [5:0] opcode, func;
  logic       alu_zero;

  always #4 clk = ~clk;

  byte_datapath dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .src_x_sel(src_x_sel),
    .src_y_sel(src_y_sel), .pc_next_sel(pc_next_sel), .pc_load(pc_load),
    .addr_sel(addr_sel), .ir_load(ir_load), .rf_we(rf_we), .dst_sel(dst_sel),
    .wb_sel(wb_sel), .alu_ctl(alu_ctl), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .opcode(opcode), .func(func), .alu_zero(alu_zero)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  m_pc, m_a, m_b, m_mdr, m_out;
  logic [31:0] m_ir;
  logic [7:0]  m_rf [8];

  function automatic logic [7:0] alu_ref(input logic [2:0] c, input logic [7:0] x, input logic [7:0] y);
    case (c)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b110: return x - y;
      3'b111: return ($signed(x) < $signed(y)) ? 8'd1 : 8'd0;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] ref_result();
    logic [7:0] x, y;
    x = src_x_sel ? m_a : m_pc;
    case (src_y_sel)
      2'b00: y = m_b;
      2'b01: y = 8'd1;
      2'b10: y = m_ir[7:0];
      default: y = m_ir[7:0] * 8'd4;
    endcase
    return alu_ref(alu_ctl, x, y);
  endfunction

  always @(posedge clk) begin
    logic [7:0] y, np, na, nb, wd;
    int wa;
    if (rst) begin
      m_pc = 0; m_a = 0; m_b = 0; m_mdr = 0; m_out = 0; m_ir = 0;
      for (int i = 0; i < 8; i++) m_rf[i] = 0;
    end else begin
      y  = ref_result();
      na = m_rf[m_ir[23:21]];
      nb = m_rf[m_ir[18:16]];
      wa = dst_sel ? int'(m_ir[13:11]) : int'(m_ir[18:16]);
      wd = wb_sel ? m_mdr : m_out;
      case (pc_next_sel)
        2'b00: np = y;
        2'b01: np = m_out;
        default: np = {m_ir[5:0], 2'b00};
      endcase
      if (rf_we && wa != 0) m_rf[wa] = wd;
      if (pc_load) m_pc = np;
      for (int k = 0; k < 4; k++) if (ir_load[k]) m_ir[k*8 +: 8] = mem_rdata;
      m_a = na; m_b = nb; m_mdr = mem_rdata; m_out = y;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R8 R7 mem_addr", mem_addr, addr_sel ? m_out : m_pc);
    chk("R11 R4 mem_wdata", mem_wdata, m_b);
    chk("R2 opcode", opcode, m_ir[31:26]);
    chk("R2 func", func, m_ir[5:0]);
    chk("R10 R9 R5 R6 alu_zero", alu_zero, ref_result() == 8'd0);
  endtask

  task automatic idle();
    src_x_sel = 0; src_y_sel = 0; pc_next_sel = 0; pc_load = 0; addr_sel = 0;
    ir_load = 0; rf_we = 0; dst_sel = 0; wb_sel = 0; alu_ctl = 3'b010; mem_rdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1 cmp_all();
  endtask

  task automatic load_ir(input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle(); ir_load[k] = 1'b1; mem_rdata = w[k*8 +: 8];
      #1 cmp_all();
    end
    @(negedge clk); idle(); #1 cmp_all();
  endtask

  task automatic write_reg(input logic [7:0] v, input logic dsel);
    @(negedge clk); idle(); mem_rdata = v; #1 cmp_all();
    @(negedge clk); idle(); rf_we = 1; wb_sel = 1; dst_sel = dsel; #1 cmp_all();
    @(negedge clk); idle(); #1 cmp_all();
    @(negedge clk); idle(); #1 cmp_all();
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 pc", mem_addr, 8'h00);
    chk("R1 wdata", mem_wdata, 8'h00);
    chk("R1 opcode", opcode, 6'h00);
    chk("R1 zero", alu_zero, 1'b1);

    load_ir(32'h8C00_0000 | (32'd0 << 16));
    write_reg(8'h5A, 1'b0);
    chk("R3 r0 after write", mem_wdata, 8'h00);

    load_ir((32'd3 << 16) | (32'd5 << 11) | 32'h2B);
    chk("R2 func byte0", func, 6'h2B);
    write_reg(8'h11, 1'b0);
    write_reg(8'h22, 1'b1);
    load_ir(32'd5 << 16);
    chk("R4 rd field write", mem_wdata, 8'h22);
    load_ir(32'd3 << 16);
    chk("R4 rt field write", mem_wdata, 8'h11);

    @(negedge clk); idle(); src_y_sel = 2'b01; #1 cmp_all();
    @(negedge clk); #1 chk("R7 pc held", mem_addr, 8'h00);
    @(negedge clk); pc_load = 1; #1 cmp_all();
    @(negedge clk); idle(); #1 chk("R7 pc step", mem_addr, 8'h01);
    load_ir(32'h0000_003F);
    @(negedge clk); idle(); pc_load = 1; pc_next_sel = 2'b10; #1 cmp_all();
    @(negedge clk); idle(); #1 chk("R7 jump target", mem_addr, 8'hFC);

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      mem_rdata   = 8'($urandom);
      src_x_sel   = 1'($urandom);
      src_y_sel   = 2'($urandom);
      pc_next_sel = 2'($urandom);
      pc_load     = 1'($urandom);
      addr_sel    = 1'($urandom);
      ir_load     = 4'($urandom);
      rf_we       = 1'($urandom);
      dst_sel     = 1'($urandom);
      wb_sel      = 1'($urandom);
      alu_ctl     = 3'($urandom);
      #1 cmp_all();
    end

    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 second reset pc", mem_addr, 8'h00);
    chk("R1 second reset ir", {opcode, func}, 12'h000);
    step();
    chk("R1 second reset regs", mem_wdata, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule